// File: doc/BRIEF.md
# Streaming Locally-Ordered Clustering Sweep

This block carries out one pass of approximate bottom-up clustering for a bounding-volume hierarchy. Axis-aligned boxes arrive one per handshake, already arranged along a space-filling curve. The block slides a search window over them. For each element it finds the cheapest partner among the `R` elements on either side. The cost of a pair is the half surface area of the box that encloses both. Two elements that chose each other leave as a single merged box. Every other element leaves unchanged, so that a later pass can try it again.

Each output carries a flag that tells a merge from a pass-through, and the stream indices of the children involved, so that tree nodes can be built downstream. The pass over a sweep ends on an input beat marked as last. The block then stalls its input for `2R` cycles and fills its windows with empty entries. This empties the windows without any special edge logic and keeps one sweep from touching the next.

Resolution trails the search by `R` elements. The outcome for element `e` is registered on the clock edge that takes in the element `2R` positions after it, whether that element is real or padding.

Top module: `ploc_sweep`

## Requirements
- R1: The nearest neighbour of a real element is the real element of the same sweep, at most R stream positions away on either side, that gives the least cost. The cost is dx*dy + dy*dz + dz*dx of the box enclosing both, where each extent is the box's max minus its min coordinate. Padding entries never win against a real element.
- R2: When costs tie, the element with the lower stream index is chosen.
- R3: Two elements that chose each other produce one output, emitted when the left (lower-index) element resolves. It has out_merged=1, out_idx_a = left index, out_idx_b = right index, and the box is the union (per-axis min of the lows, max of the highs).
- R4: An element without a mutual partner is emitted with out_merged=0, its own box, and out_idx_a = out_idx_b = its own index.
- R5: The right member of a merge emits nothing and padding entries never reach the output. Across a run, the number of outputs equals the number of pass-throughs plus merges.
- R6: Within a sweep, outputs appear in ascending order of the emitting element's index.
- R7: After a beat accepted with in_last=1, in_ready is low for exactly 2R cycles. Every output of that sweep has appeared by the time in_ready is high again.
- R8: Stream indices restart at 0 with each sweep, and elements of different sweeps never merge.
- R9: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input box offered |
| in_ready | output | 1 | Input may be taken; low while padding |
| in_last | input | 1 | Offered box is the last of its sweep |
| in_lo | input | 3*COORD_W | Box minimum corner, x in the low bits, then y, then z |
| in_hi | input | 3*COORD_W | Box maximum corner, same packing |
| out_valid | output | 1 | One-cycle strobe for an output record |
| out_merged | output | 1 | 1 for a merged pair, 0 for a pass-through |
| out_lo | output | 3*COORD_W | Output box minimum corner |
| out_hi | output | 3*COORD_W | Output box maximum corner |
| out_idx_a | output | IDX_W | Left child index, or own index |
| out_idx_b | output | IDX_W | Right child index, or own index |

## Verification
The bench goes after tie-breaking with three evenly spaced boxes. Breaking the tie toward the higher index would pair the middle box with its right neighbour rather than its left one. It runs sweeps of one and two elements. There, a design that took padding for a neighbour would wrongly merge or drop a box. It runs sweeps back to back with no idle cycles, where an index that does not restart, or a window that does not fully drain, would corrupt the child indices or leak merges across the sweep boundary. Random sweeps with coarse coordinates produce many equal costs and uneven mutual patterns. A design that emitted the right member of a pair, or lost a lone element, would show a wrong output count or sequence. So would one that resolved too late for 2R padding entries to flush it.

// File: rtl/ploc_pkg.sv
package ploc_pkg;
  localparam int COORD_W = 8;
  localparam int IDX_W   = 10;
  localparam int COST_W  = 2 * COORD_W + 2;

  typedef logic [2:0][COORD_W-1:0] vec3_t;

  typedef struct packed {
    vec3_t lo;
    vec3_t hi;
  } box_t;

  typedef struct packed {
    box_t             box;
    logic             live;
    logic [IDX_W-1:0] idx;
  } elem_t;

  function automatic box_t box_union(box_t a, box_t b);
    box_t u;
    for (int ax = 0; ax < 3; ax++) begin
      u.lo[ax] = (a.lo[ax] < b.lo[ax]) ? a.lo[ax] : b.lo[ax];
      u.hi[ax] = (a.hi[ax] > b.hi[ax]) ? a.hi[ax] : b.hi[ax];
    end
    return u;
  endfunction

  function automatic logic [COST_W-1:0] half_area(box_t b);
    logic [COST_W-1:0] ext [3];
    for (int ax = 0; ax < 3; ax++)
      ext[ax] = COST_W'(b.hi[ax]) - COST_W'(b.lo[ax]);
    return ext[0] * ext[1] + ext[1] * ext[2] + ext[2] * ext[0];
  endfunction

  function automatic logic [COST_W-1:0] pair_cost(box_t a, box_t b);
    return half_area(box_union(a, b));
  endfunction
endpackage

// File: rtl/ploc_nn_pick.sv
module ploc_nn_pick
  import ploc_pkg::*;
#(
  parameter int R = 2
) (
  input  elem_t [2*R:0]                       win,
  output logic signed [$clog2(R+1):0]         off,
  output logic [COST_W-1:0]                   best_cost
);
  localparam int N     = 2 * R + 1;
  localparam int OFF_W = $clog2(R + 1) + 1;

  logic [N-1:0][COST_W-1:0] cost;

  for (genvar p = 0; p < N; p++) begin : g_cost
    if (p == R) begin : g_self
      assign cost[p] = '1;
    end else begin : g_nb
      assign cost[p] = win[p].live ? pair_cost(win[R].box, win[p].box) : '1;
    end
  end

  // Position 0 holds the newest (highest index); scanning upward with <=
  // lets the lowest index win a tie.
  always_comb begin
    logic [COST_W-1:0] best;
    int bp;
    best = '1;
    bp   = 0;
    for (int p = 0; p < N; p++) begin
      if (p != R && cost[p] <= best) begin
        best = cost[p];
        bp   = p;
      end
    end
    off       = OFF_W'(R - bp);
    best_cost = best;
  end
endmodule

// File: rtl/ploc_pair_resolve.sv
module ploc_pair_resolve
  import ploc_pkg::*;
#(
  parameter int R = 2
) (
  input  elem_t [2*R:0]                         v,
  input  logic  [2*R:0][$clog2(R+1):0]          offs,
  output logic                                  mutual,
  output logic                                  emit,
  output logic                                  merged,
  output box_t                                  box,
  output logic [IDX_W-1:0]                      idx_a,
  output logic [IDX_W-1:0]                      idx_b
);
  localparam int N     = 2 * R + 1;
  localparam int OFF_W = $clog2(R + 1) + 1;

  // v[k] is the element k positions older than v[0]; a positive offset
  // points to a younger element, so partner sits at position R - d.
  always_comb begin
    logic signed [OFF_W-1:0] d;
    logic signed [OFF_W-1:0] pk;
    elem_t                   partner;
    logic signed [OFF_W-1:0] poff;
    d       = offs[R];
    partner = '0;
    poff    = '0;
    for (int k = 0; k < N; k++) begin
      pk = offs[k];
      if (k == R - int'(d)) begin
        partner = v[k];
        poff    = pk;
      end
    end
    mutual = v[R].live && partner.live && (int'(poff) == -int'(d));
    merged = mutual && (d > 0);
    emit   = v[R].live && (!mutual || d > 0);
    box    = merged ? box_union(v[R].box, partner.box) : v[R].box;
    idx_a  = v[R].idx;
    idx_b  = merged ? partner.idx : v[R].idx;
  end
endmodule

// File: rtl/ploc_sweep.sv
module ploc_sweep
  import ploc_pkg::*;
#(
  parameter int R = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   in_last,
  input  logic [3*COORD_W-1:0]   in_lo,
  input  logic [3*COORD_W-1:0]   in_hi,
  output logic                   out_valid,
  output logic                   out_merged,
  output logic [3*COORD_W-1:0]   out_lo,
  output logic [3*COORD_W-1:0]   out_hi,
  output logic [IDX_W-1:0]       out_idx_a,
  output logic [IDX_W-1:0]       out_idx_b
);
  localparam int N     = 2 * R + 1;
  localparam int HIST  = 2 * R;
  localparam int OFF_W = $clog2(R + 1) + 1;
  localparam int PAD_W = $clog2(2 * R + 1);

  // ---------------- state ----------------
  elem_t [HIST-1:0]            win;     // boxes waiting around the centre
  elem_t [HIST-1:0]            nnel;    // searched elements, newest first
  logic  [HIST-1:0][OFF_W-1:0] nnoff;   // their chosen neighbour offsets
  logic  [IDX_W-1:0]           idx_cnt;
  logic  [PAD_W-1:0]           pad_cnt;

  // ---------------- named events ----------------
  logic accept, padding, step;
  assign padding  = (pad_cnt != '0);
  assign in_ready = !padding;
  assign accept   = in_valid && in_ready;
  assign step     = accept || padding;

  elem_t incoming;
  always_comb begin
    incoming.box.lo = vec3_t'(in_lo);
    incoming.box.hi = vec3_t'(in_hi);
    incoming.live   = accept;
    incoming.idx    = idx_cnt;
  end

  // Window as it stands once the incoming entry is shifted in.
  elem_t [N-1:0] nw;
  always_comb begin
    nw[0] = incoming;
    for (int p = 1; p < N; p++) nw[p] = win[p-1];
  end

  logic signed [OFF_W-1:0] c_off;
  logic [COST_W-1:0]       c_cost;

  ploc_nn_pick #(.R(R)) u_pick (
    .win       (nw),
    .off       (c_off),
    .best_cost (c_cost)
  );

  // Resolution view: fresh search result followed by the history.
  elem_t [N-1:0]            v;
  logic  [N-1:0][OFF_W-1:0] voff;
  always_comb begin
    v[0]    = nw[R];
    voff[0] = c_off;
    for (int k = 1; k < N; k++) begin
      v[k]    = nnel[k-1];
      voff[k] = nnoff[k-1];
    end
  end

  logic             r_mutual, r_emit, r_merged;
  box_t             r_box;
  logic [IDX_W-1:0] r_idx_a, r_idx_b;

  ploc_pair_resolve #(.R(R)) u_resolve (
    .v      (v),
    .offs   (voff),
    .mutual (r_mutual),
    .emit   (r_emit),
    .merged (r_merged),
    .box    (r_box),
    .idx_a  (r_idx_a),
    .idx_b  (r_idx_b)
  );

  // ---------------- registers ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win        <= '0;
      nnel       <= '0;
      nnoff      <= '0;
      idx_cnt    <= '0;
      pad_cnt    <= '0;
      out_valid  <= 1'b0;
      out_merged <= 1'b0;
      out_lo     <= '0;
      out_hi     <= '0;
      out_idx_a  <= '0;
      out_idx_b  <= '0;
    end else begin
      out_valid <= step && r_emit;
      if (step) begin
        win   <= nw[HIST-1:0];
        nnel  <= v[HIST-1:0];
        nnoff <= voff[HIST-1:0];
        if (r_emit) begin
          out_merged <= r_merged;
          out_lo     <= r_box.lo;
          out_hi     <= r_box.hi;
          out_idx_a  <= r_idx_a;
          out_idx_b  <= r_idx_b;
        end
      end
      if (accept) idx_cnt <= in_last ? '0 : idx_cnt + 1'b1;
      if (accept && in_last) pad_cnt <= PAD_W'(2 * R);
      else if (padding)      pad_cnt <= pad_cnt - 1'b1;
    end
  end

  // ---------------- assertions ----------------
  a_r1_live_pick_finite: assert property (@(posedge clk) disable iff (!rst_n)
    (step && nw[R].live && nw[R+1].live) |-> (c_cost != '1));

  a_r3_merge_ordered: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_merged) |-> (out_idx_a < out_idx_b));

  a_r3_merge_in_reach: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_merged) |-> ((out_idx_b - out_idx_a) <= IDX_W'(R)));

  a_r4_pass_own_index: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_merged) |-> (out_idx_a == out_idx_b));

  a_r5_mutual_needs_live: assert property (@(posedge clk) disable iff (!rst_n)
    r_mutual |-> v[R].live);

  a_r7_last_starts_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> !in_ready);
endmodule

// File: tb/ploc_sweep_bench.sv
`timescale 1ns/1ps
module ploc_sweep_bench;
  import ploc_pkg::COORD_W;
  import ploc_pkg::IDX_W;

  localparam int R   = 2;
  localparam int W   = COORD_W;
  localparam int MAXO = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic in_ready;
  logic [3*W-1:0] in_lo = '0, in_hi = '0;
  logic out_valid, out_merged;
  logic [3*W-1:0] out_lo, out_hi;
  logic [IDX_W-1:0] out_idx_a, out_idx_b;

  always #5 clk = ~clk;

  ploc_sweep #(.R(R)) u_ploc_sweep (
    .clk, .rst_n, .in_valid, .in_ready, .in_last, .in_lo, .in_hi,
    .out_valid, .out_merged, .out_lo, .out_hi, .out_idx_a, .out_idx_b
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // sweep scratch
  logic [3*W-1:0] s_lo [64];
  logic [3*W-1:0] s_hi [64];

  // expected and observed records
  logic           e_m [MAXO];
  int             e_a [MAXO], e_b [MAXO];
  logic [3*W-1:0] e_lo [MAXO], e_hi [MAXO];
  string          e_tag [MAXO];
  int             e_n = 0;
  logic           g_m [MAXO];
  int             g_a [MAXO], g_b [MAXO];
  logic [3*W-1:0] g_lo [MAXO], g_hi [MAXO];
  int             g_n = 0;

  always @(negedge clk) begin
    if (rst_n && out_valid && g_n < MAXO) begin
      g_m[g_n] = out_merged; g_a[g_n] = out_idx_a; g_b[g_n] = out_idx_b;
      g_lo[g_n] = out_lo;    g_hi[g_n] = out_hi;
      g_n++;
    end
  end

  function automatic int crd(logic [3*W-1:0] v, int ax);
    return int'(v[ax*W +: W]);
  endfunction

  // enclosing box half-area, written per axis
  function automatic longint enc_cost(int i, int j);
    longint ext [3];
    for (int ax = 0; ax < 3; ax++) begin
      int mn, mx;
      mn = crd(s_lo[i], ax) < crd(s_lo[j], ax) ? crd(s_lo[i], ax) : crd(s_lo[j], ax);
      mx = crd(s_hi[i], ax) > crd(s_hi[j], ax) ? crd(s_hi[i], ax) : crd(s_hi[j], ax);
      ext[ax] = mx - mn;
    end
    return ext[0]*ext[1] + ext[1]*ext[2] + ext[2]*ext[0];
  endfunction

  function automatic logic [3*W-1:0] pick_lo(int i, int j);
    logic [3*W-1:0] r;
    for (int ax = 0; ax < 3; ax++)
      r[ax*W +: W] = W'(crd(s_lo[i], ax) < crd(s_lo[j], ax) ? crd(s_lo[i], ax) : crd(s_lo[j], ax));
    return r;
  endfunction

  function automatic logic [3*W-1:0] pick_hi(int i, int j);
    logic [3*W-1:0] r;
    for (int ax = 0; ax < 3; ax++)
      r[ax*W +: W] = W'(crd(s_hi[i], ax) > crd(s_hi[j], ax) ? crd(s_hi[i], ax) : crd(s_hi[j], ax));
    return r;
  endfunction

  // Reference: neighbour choice, mutual pairing, ordered emission.
  task automatic model_sweep(int n, string tag);
    int nn [64];
    for (int i = 0; i < n; i++) begin
      longint bc;
      nn[i] = -1; bc = 0;
      for (int j = i - R; j <= i + R; j++) begin
        if (j >= 0 && j < n && j != i) begin
          longint c;
          c = enc_cost(i, j);
          if (nn[i] < 0 || c < bc) begin nn[i] = j; bc = c; end
        end
      end
    end
    for (int i = 0; i < n; i++) begin
      bit mut;
      mut = (nn[i] >= 0) && (nn[nn[i]] == i);
      if (mut && nn[i] < i) continue;
      if (e_n >= MAXO) continue;
      e_m[e_n] = mut; e_a[e_n] = i; e_b[e_n] = mut ? nn[i] : i;
      e_lo[e_n] = mut ? pick_lo(i, nn[i]) : s_lo[i];
      e_hi[e_n] = mut ? pick_hi(i, nn[i]) : s_hi[i];
      e_tag[e_n] = tag;
      e_n++;
    end
  endtask

  task automatic set_box(int i, int x, int y, int z, int dx, int dy, int dz);
    s_lo[i] = {W'(z), W'(y), W'(x)};
    s_hi[i] = {W'(z+dz), W'(y+dy), W'(x+dx)};
  endtask

  task automatic rand_boxes(int n, bit coarse);
    for (int i = 0; i < n; i++) begin
      if (coarse)
        set_box(i, 16*($urandom%6), 16*($urandom%3), 16*($urandom%3),
                16*($urandom%3), 16*($urandom%3), 16*($urandom%3));
      else
        set_box(i, $urandom%200, $urandom%200, $urandom%200,
                $urandom%56, $urandom%56, $urandom%56);
    end
  endtask

  task automatic drive_sweep(int n, int gap_max, string tag);
    int pad;
    model_sweep(n, tag);
    for (int i = 0; i < n; i++) begin
      int gaps;
      gaps = (gap_max > 0) ? int'($urandom % (gap_max + 1)) : 0;
      repeat (gaps) begin @(negedge clk); #1; in_valid = 1'b0; end
      @(negedge clk); #1;
      while (!in_ready) begin in_valid = 1'b0; @(negedge clk); #1; end
      in_valid = 1'b1; in_lo = s_lo[i]; in_hi = s_hi[i];
      in_last = (i == n - 1);
    end
    @(negedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0;
    pad = 0;
    while (!in_ready && pad < 100) begin pad++; @(negedge clk); #1; end
    // R7: stall length and drained output count
    check(pad == 2*R, "R7", "padding stall cycles", pad, 2*R);
    check(g_n == e_n, "R7", "outputs delivered at sweep end", g_n, e_n);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    check(in_ready == 1'b1, "R9", "in_ready after reset", in_ready, 1);
    check(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);

    // single element: only padding around it -> pass-through
    set_box(0, 10, 10, 10, 5, 5, 5);
    drive_sweep(1, 0, "R4");
    // two elements -> always a mutual pair
    set_box(0, 0, 0, 0, 4, 4, 4); set_box(1, 100, 100, 100, 4, 4, 4);
    drive_sweep(2, 1, "R3");
    // evenly spaced: middle ties, lower index must win
    set_box(0, 0, 0, 0, 2, 2, 2); set_box(1, 10, 0, 0, 2, 2, 2);
    set_box(2, 20, 0, 0, 2, 2, 2);
    drive_sweep(3, 0, "R2");
    // two clusters
    set_box(0, 0, 0, 0, 3, 3, 3);  set_box(1, 1, 1, 1, 3, 3, 3);
    set_box(2, 90, 90, 90, 3, 3, 3); set_box(3, 91, 91, 91, 3, 3, 3);
    set_box(4, 200, 0, 0, 3, 3, 3);
    drive_sweep(5, 0, "R3");

    for (int s = 0; s < 36; s++) begin
      int n;
      n = 1 + int'($urandom % 40);
      rand_boxes(n, s % 3 == 0);
      drive_sweep(n, (s % 2 == 0) ? 0 : 3, (s % 2 == 0) ? "R8" : "R1");
    end

    repeat (4) @(negedge clk);
    #1;
    check(g_n == e_n, "R5", "total output count", g_n, e_n);
    for (int i = 0; i < e_n && i < g_n; i++) begin
      check(g_m[i] == e_m[i], e_m[i] ? "R3" : "R4", "merged flag", g_m[i], e_m[i]);
      check(g_a[i] == e_a[i], "R6", "idx_a", g_a[i], e_a[i]);
      check(g_b[i] == e_b[i], e_tag[i], "idx_b", g_b[i], e_b[i]);
      check(g_lo[i] == e_lo[i], e_m[i] ? "R3" : "R4", "box lo", g_lo[i], e_lo[i]);
      check(g_hi[i] == e_hi[i], e_m[i] ? "R3" : "R4", "box hi", g_hi[i], e_hi[i]);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R5 watchdog: actual=%0d outputs expected=%0d before timeout", g_n, e_n);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule